// File: doc/BRIEF.md
# Periodic Interval Timer with Elapsed-Period Count

This block is a memory-mapped timer that produces a steady periodic event for an operating system tick. A fixed divide-by-16 prescaler turns the system clock into slow ticks. A 20-bit value counter climbs by one on each slow tick and returns to zero once it has passed the programmed period. Each return to zero adds one to a 12-bit elapsed-period count and raises a pending flag. A level interrupt follows the pending flag whenever interrupts are enabled.

Software reaches the block through a simple single-cycle register bus. The elapsed-period count and the live counter value can be read in two ways. One read acknowledges the count, so software can see how many periods it missed and clear them in a single access. The other read has no side effects and is meant for fine-grained time reads. Clearing the enable does not halt the counter at once. The counter finishes its current period, stops at zero, and software can poll the value field until it reads zero.

Top module: `period_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped and `irq` is low.
- R2: The control register at offset 0x0 holds the period value in bits [19:0], the enable in bit 24 and the interrupt enable in bit 25. A read returns these bits and zero in every other bit.
- R3: While running, the counter value increments once every 16 clocks. On the slow tick where the value is at or above the period value it returns to 0, so one period lasts (period + 1) x 16 clocks.
- R4: Each return to zero adds one to the elapsed-period count, which wraps modulo 4096, and sets the pending flag. The pending flag is bit 0 of offset 0x4.
- R5: A read of offset 0x8 returns the count in bits [31:20] and the counter value in bits [19:0], then clears the count and the pending flag. If a return to zero happens in the same cycle, the count becomes 1 and the flag stays set.
- R6: A read of offset 0xC returns the same fields as offset 0x8 and changes neither the count nor the pending flag.
- R7: `irq` is high exactly while the pending flag and the interrupt enable are both set. Counting continues while interrupts are disabled.
- R8: After the enable is cleared, the counter runs on until its next return to zero and then holds at zero.
- R9: Writes to offsets 0x4, 0x8 and 0xC are ignored.
- R10: A control write with the enable set starts counting from zero with a cleared prescaler, but only when the counter is stopped. The same write to a running counter does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Level interrupt request |

## Verification
Some properties are checked on every cycle:
- `irq` never rises without both the pending flag and the interrupt enable.
- The counter value stays put between slow ticks.
- A return to zero always raises the flag and adds one to the count.
- An acknowledging read leaves a count of 0, or of 1 on a collision with a return to zero.
- A stopped counter holds its value, and the counter only stops at zero.

The exact 16-clock spacing, the period length and the run-on after the enable is cleared can only be shown by the bench's timed register reads. The same holds for the side-effect-free image read, the ignored writes and the rule that a running counter is not restarted.

// File: rtl/period_timer_pkg.sv
// Shared constants of the periodic interval timer: register offsets and
// control bit positions. Assumes a 4-bit byte-offset register bus.
package period_timer_pkg;
    localparam int          BUS_W       = 32;
    localparam int          ADDR_W      = 4;
    localparam logic [3:0]  OFS_CTRL    = 4'h0;
    localparam logic [3:0]  OFS_PEND    = 4'h4;
    localparam logic [3:0]  OFS_ACKVAL  = 4'h8;
    localparam logic [3:0]  OFS_PEEK    = 4'hC;
    localparam int          BIT_RUN_EN  = 24;
    localparam int          BIT_IRQ_EN  = 25;
    localparam int          CNT_LSB     = 20;

    // Decoded control register contents.
    typedef struct packed {
        logic irq_en;
        logic run_en;
    } ctrl_flags_t;
endpackage

// File: rtl/pt_prescaler.sv
// Clock prescaler: emits a one-cycle slow tick every DIV clocks while run
// is high. It is held at zero while stopped and forced to zero by clr.
// Assumes DIV >= 1.
module pt_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_nodiv
            // No division: every running cycle is a tick.
            assign tick = run && !clr;
        end else begin : g_div
            localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);
            logic [PRE_W-1:0] pre_q;

            // Divider state: counts 0..DIV-1 while running, else held at 0.
            always_ff @(posedge clk) begin
                if (!rst_n || clr || !run) begin
                    pre_q <= '0;
                end else if (pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = run && !clr && (pre_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pt_value_ctr.sv
// Period value counter: counts slow ticks, returns to zero once it has
// reached the period and flags each return. It stops at zero when the
// enable is low at a return. A start pulse is honoured only when stopped.
module pt_value_ctr #(
    parameter int VAL_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             run_en,
    input  logic [VAL_W-1:0] period,
    output logic [VAL_W-1:0] value,
    output logic             running,
    output logic             wrap
);
    logic at_end;

    // Detect the tick on which the counter returns to zero.
    always_comb begin
        at_end = (value >= period);
        wrap   = running && tick && at_end;
    end

    // Counter and run flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value   <= '0;
            running <= 1'b0;
        end else if (start && !running) begin
            value   <= '0;
            running <= 1'b1;
        end else if (running && tick) begin
            if (at_end) begin
                value <= '0;
                if (!run_en) begin
                    running <= 1'b0;
                end
            end else begin
                value <= value + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pt_period_log.sv
// Elapsed-period log: counts returns to zero modulo 2**CNT_W and keeps a
// pending flag. An acknowledge clears both, but a return to zero in the
// same cycle is kept.
module pt_period_log #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             ack,
    output logic [CNT_W-1:0] count,
    output logic             pending
);
    // Count and flag update, acknowledge first, collision-safe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            pending <= 1'b0;
        end else if (ack) begin
            count   <= wrap ? CNT_W'(1) : '0;
            pending <= wrap;
        end else if (wrap) begin
            count   <= count + 1'b1;
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/pt_regfile.sv
// Register front end: holds the control register, decodes accesses,
// produces the start and acknowledge strobes and muxes the read data.
// Assumes one-cycle accesses and VAL_W <= CNT_LSB.
module pt_regfile
    import period_timer_pkg::*;
#(
    parameter int VAL_W = 20,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [VAL_W-1:0]  value,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    output logic [VAL_W-1:0]  period,
    output ctrl_flags_t       flags,
    output logic              start,
    output logic              ack
);
    logic ctrl_wr;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Access decode: control write, start request, acknowledging read.
    always_comb begin
        ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
        start   = ctrl_wr && bus_wdata[BIT_RUN_EN];
        ack     = bus_sel && !bus_wr && (bus_addr == OFS_ACKVAL);
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            flags  <= '0;
        end else if (ctrl_wr) begin
            period       <= bus_wdata[VAL_W-1:0];
            flags.run_en <= bus_wdata[BIT_RUN_EN];
            flags.irq_en <= bus_wdata[BIT_IRQ_EN];
        end
    end

    // Read data mux; unused offsets and bits read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[VAL_W-1:0]  = period;
                    bus_rdata[BIT_RUN_EN] = flags.run_en;
                    bus_rdata[BIT_IRQ_EN] = flags.irq_en;
                end
                OFS_PEND: begin
                    bus_rdata[0] = pending;
                end
                OFS_ACKVAL, OFS_PEEK: begin
                    bus_rdata[VAL_W-1:0]       = value;
                    bus_rdata[CNT_LSB +: CNT_W] = count;
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/period_timer.sv
// Periodic interval timer top: prescaler, value counter, elapsed-period
// log and register front end, plus the gated level interrupt.
// Assumes a synchronous active-low reset and one-cycle bus accesses.
module period_timer
    import period_timer_pkg::*;
#(
    parameter int DIV   = 16,
    parameter int VAL_W = 20,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [VAL_W-1:0] period;
    logic [VAL_W-1:0] value;
    logic [CNT_W-1:0] count;
    ctrl_flags_t      flags;
    logic             pending;
    logic             start;
    logic             ack;
    logic             tick;
    logic             running;
    logic             wrap;
    logic             pre_clr;

    assign pre_clr = start && !running;

    pt_regfile #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .value(value), .count(count), .pending(pending),
        .period(period), .flags(flags), .start(start), .ack(ack)
    );

    pt_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .clr(pre_clr), .tick(tick)
    );

    pt_value_ctr #(.VAL_W(VAL_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .run_en(flags.run_en), .period(period),
        .value(value), .running(running), .wrap(wrap)
    );

    pt_period_log #(.CNT_W(CNT_W)) u_log (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack),
        .count(count), .pending(pending)
    );

    // Level interrupt gated by the interrupt enable.
    always_comb begin
        irq = pending && flags.irq_en;
    end
endmodule

// File: rtl/period_timer_chk.sv
// Assertion checker for period_timer, attached by bind. It observes the
// interrupt output and the signals passed between the submodules.
module period_timer_chk #(
    parameter int VAL_W = 20,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             irq_en,
    input logic             pending,
    input logic             wrap,
    input logic             ack,
    input logic             tick,
    input logic             start,
    input logic             running,
    input logic [VAL_W-1:0] value,
    input logic [CNT_W-1:0] count
);
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en); // R7
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending); // R7
    AST_VALUE_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(value)); // R3
    AST_WRAP_LOGS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ack) |=> (pending && count == $past(count) + 1'b1)); // R4
    AST_ACK_CLEARS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (pending == $past(wrap)) && (count == ($past(wrap) ? CNT_W'(1) : CNT_W'(0)))); // R5
    AST_STOP_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (value == '0)); // R8
    AST_STOPPED_IS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> (value == $past(value))); // R8
endmodule

bind period_timer period_timer_chk #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_en(flags.irq_en),
    .pending(pending), .wrap(wrap), .ack(ack), .tick(tick), .start(start),
    .running(running), .value(value), .count(count)
);

// File: tb/period_timer_bench.sv
// Scoreboard bench: driver tasks push expected values, a monitor pops and
// compares them at a quarter period after each access is driven.
module period_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int pos = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          kind_q[$];
    event        smp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    period_timer u_period_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // Monitor: pop one expected item per sample strobe and compare.
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                logic [31:0] a;
                string t;
                bit k;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                k = kind_q.pop_front();
                a = k ? {31'd0, irq} : bus_rdata;
                n_chk++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: got 0x%08h expected 0x%08h", t, a, e);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t); kind_q.push_back(1'b0);
        #(CLK_PERIOD/4);
        ->smp_ev;
        @(negedge clk);
        bus_sel = 1'b0;
        pos++;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        pos++;
    endtask

    task automatic irq_chk(input bit e, input string t);
        exp_q.push_back({31'd0, e}); tag_q.push_back(t); kind_q.push_back(1'b1);
        #(CLK_PERIOD/4);
        ->smp_ev;
        @(negedge clk);
        pos++;
    endtask

    task automatic go_to(input int target);
        while (pos < target) begin
            @(negedge clk);
            pos++;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus: offsets 0x0 ctrl, 0x4 pending, 0x8 ack-read, 0xC peek.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        irq_chk(1'b0, "R1 irq after reset");
        rd(4'h0, 32'h0, "R1 ctrl after reset");
        rd(4'h4, 32'h0, "R1 pending after reset");
        rd(4'hC, 32'h0, "R1 peek after reset");
        rd(4'h8, 32'h0, "R1 ackval after reset");

        // Start: period 3, enable, junk in unused bits (R2, R10)
        wr(4'h0, 32'hFDF0_0003);
        pos = 0;
        rd(4'h0, 32'h0100_0003, "R2 ctrl readback masks bits");
        go_to(15); rd(4'hC, 32'h0000_0000, "R3 no step before 16 clocks");
        rd(4'hC, 32'h0000_0001, "R3 step at 16 clocks");
        go_to(63); rd(4'hC, 32'h0000_0003, "R3 value at period");
        rd(4'h4, 32'h1, "R4 pending after first wrap");
        rd(4'hC, 32'h0010_0000, "R4 count 1 and value 0");
        irq_chk(1'b0, "R7 irq masked while pending");
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, 32'h0010_0000, "R9 peek after ignored writes");
        rd(4'h4, 32'h1, "R6 r9_ pending kept");
        rd(4'h0, 32'h0100_0003, "R9 ctrl unchanged");
        go_to(128); rd(4'hC, 32'h0020_0000, "R4 count accumulates to 2");
        rd(4'h8, 32'h0020_0000, "R5 ackval returns count");
        rd(4'h4, 32'h0, "R5 pending cleared by ack");
        rd(4'hC, 32'h0000_0000, "R5 count cleared by ack");

        // Ack colliding with a wrap (R5)
        go_to(191); rd(4'h8, 32'h0000_0003, "R5 ack on wrap cycle");
        rd(4'h4, 32'h1, "R5 pending kept on collision");
        rd(4'hC, 32'h0010_0000, "R5 count 1 on collision");

        // Enable irq on a running timer: no restart (R7, R10)
        go_to(194); wr(4'h0, 32'h0300_0003);
        irq_chk(1'b1, "R7 irq when pending and enabled");
        go_to(210); rd(4'hC, 32'h0010_0001, "R10 running timer not restarted");
        rd(4'h8, 32'h0010_0001, "R5 ackval with irq enabled");
        irq_chk(1'b0, "R7 irq drops after ack");

        // Disable: run on to zero then hold (R8)
        wr(4'h0, 32'h0200_0003);
        go_to(240); rd(4'hC, 32'h0000_0003, "R8 still counting after disable");
        go_to(300); rd(4'hC, 32'h0010_0000, "R8 stopped at zero after wrap");
        rd(4'h4, 32'h1, "R8 final wrap logged");
        irq_chk(1'b1, "R7 irq from final wrap");
        rd(4'h8, 32'h0010_0000, "R8 ack final wrap");
        go_to(400); rd(4'hC, 32'h0000_0000, "R8 value held at zero");
        rd(4'h4, 32'h0, "R8 no further wraps");

        // Restart from stopped with period 1 (R10, R3)
        wr(4'h0, 32'h0100_0001);
        pos = 0;
        go_to(15); rd(4'hC, 32'h0000_0000, "R10 restart from zero");
        rd(4'hC, 32'h0000_0001, "R10 fresh prescaler step at 16");
        go_to(31); rd(4'hC, 32'h0000_0001, "R3 period 1 at end");
        rd(4'hC, 32'h0010_0000, "R3 period 1 wraps at 32");
        rd(4'h4, 32'h1, "R4 pending for period 1");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule